// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns their full product of `2*WIDTH` bits. All multiplication comes from a fixed 2x2 cell. That cell forms its four product bits directly from AND terms and a little XOR/AND logic, with no adder. Wider multipliers are built by recursion:

- Each operand is cut into a high half and a low half.
- Four half-width multipliers form the four half products.
- Two ripple-carry adders merge the half products into the final result.

`WIDTH` must be a power of two from 2 to 16. Any other value stops elaboration. The parameter `OUT_REG` selects where the product is taken:

- When `OUT_REG` is set, the product is captured in an output register that reset clears.
- When `OUT_REG` is clear, the product is a purely combinational function of the operands.

Top module: `vcx_multiplier`

## Requirements
- R1: In the 2x2 cell, product bit 0 is the AND of both operands' bit 0.
- R2: In the 2x2 cell, product bit 1 is (a1 AND b0) XOR (a0 AND b1).
- R3: In the 2x2 cell, product bit 2 is (a1 AND b1) XOR (a1b0 AND a0b1), and product bit 3 is high only when both operands equal 3.
- R4: A 2-bit multiply yields only the values 0, 1, 2, 3, 4, 6 and 9.
- R5: Each ripple-carry adder starts with carry-in 0 and passes each bit's carry to the next bit, so that {carry-out, sum} equals a + b.
- R6: The low WIDTH/2 product bits equal the low WIDTH/2 bits of the product of the two operands' low halves.
- R7: For WIDTH of 2, 4, 8 and 16, the product equals the unsigned value opA * opB.
- R8: With OUT_REG = 1, the product appears at the output one clock edge after the operands are sampled, and it reads 0 while rstN is low.
- R9: With OUT_REG = 0, the product follows the operands in the same cycle, with no clock edge in between.
- R10: Merging the half products never produces a carry out of the top `3*WIDTH/2` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset; clears the output register |
| opA | input | WIDTH | Unsigned multiplicand |
| opB | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Unsigned product opA*opB |

## Verification
Operands are driven just after a falling edge.

- The combinational variant (R9) is due once the logic settles, so it is checked 1 ns after the operands are driven, before any rising edge.
- The registered variants (R7, R8) are due at the rising edge that follows. They are checked at the next falling edge, while the operands are still held, so every expected value comes from the operands currently applied.
- The reset value is checked at a falling edge while rstN is still low.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

  typedef struct packed {
    logic load;
    logic clear;
  } vcmCtl_t;

  function automatic bit isPow2(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/vcm_cell2.sv
module vcm_cell2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] q
);
  logic vLo, crossA, crossB, vHi;

  always_comb begin
    vLo    = a[0] & b[0];
    crossA = a[1] & b[0];
    crossB = a[0] & b[1];
    vHi    = a[1] & b[1];
    q[0]   = vLo;
    q[1]   = crossA ^ crossB;
    q[2]   = vHi ^ (crossA & crossB);
    q[3]   = vHi & crossA & crossB;
  end

  // R4: only the legal product values can appear
  always_comb begin
    if (!$isunknown({a, b})) begin
      a_r4_value_set: assert (q inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd9})
        else $error("cell product outside legal set");
      a_r3_top_bit: assert (!q[3] || (a == 2'd3 && b == 2'd3))
        else $error("cell bit 3 set for non-3x3 operands");
    end
  end
endmodule

// File: rtl/vcm_rca.sv
module vcm_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end

  assign cout = carry[W];

  // R5: ripple chain adds exactly
  always_comb begin
    if (!$isunknown({a, b})) begin
      a_r5_sum: assert ({cout, sum} == ({1'b0, a} + {1'b0, b}))
        else $error("ripple adder sum mismatch");
    end
  end
endmodule

// File: rtl/vcm_mul.sv
module vcm_mul #(
  parameter int N = 4
) (
  input  logic [N-1:0]   aIn,
  input  logic [N-1:0]   bIn,
  output logic [2*N-1:0] product
);
  localparam int H = N / 2;

  if (N == 2) begin : g_base
    vcm_cell2 u_cell (.a(aIn), .b(bIn), .q(product));
  end else begin : g_split
    logic [H-1:0]   aLo, aHi, bLo, bHi;
    logic [N-1:0]   pLL, pLH, pHL, pHH;
    logic [N-1:0]   midSum;
    logic           midC;
    logic [N+H-1:0] upSum;
    logic           upC;
    logic [N-1:0]   refLow;

    assign aLo = aIn[H-1:0];
    assign aHi = aIn[N-1:H];
    assign bLo = bIn[H-1:0];
    assign bHi = bIn[N-1:H];

    vcm_mul #(.N(H)) u_ll (.aIn(aLo), .bIn(bLo), .product(pLL));
    vcm_mul #(.N(H)) u_lh (.aIn(aLo), .bIn(bHi), .product(pLH));
    vcm_mul #(.N(H)) u_hl (.aIn(aHi), .bIn(bLo), .product(pHL));
    vcm_mul #(.N(H)) u_hh (.aIn(aHi), .bIn(bHi), .product(pHH));

    vcm_rca #(.W(N)) u_mid (
      .a(pLH), .b(pHL), .sum(midSum), .cout(midC)
    );

    vcm_rca #(.W(N + H)) u_up (
      .a({pHH, pLL[N-1:H]}),
      .b({{(H-1){1'b0}}, midC, midSum}),
      .sum(upSum),
      .cout(upC)
    );

    assign product = {upSum, pLL[H-1:0]};

    assign refLow = N'(aLo) * N'(bLo);

    // R6 and R10 checks beside the merge logic
    always_comb begin
      if (!$isunknown({aIn, bIn})) begin
        a_r6_low_half: assert (product[H-1:0] == refLow[H-1:0])
          else $error("low half does not match low-half product");
        a_r10_no_spill: assert (!upC)
          else $error("upper merge produced a carry out");
      end
    end
  end
endmodule

// File: rtl/vcm_ctrl.sv
module vcm_ctrl
  import vcm_pkg::*;
(
  input  logic    rstN,
  output vcmCtl_t ctl
);
  always_comb begin
    ctl.clear = ~rstN;
    ctl.load  = rstN;
  end
endmodule

// File: rtl/vcm_datapath.sv
module vcm_datapath
  import vcm_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  vcmCtl_t            ctl,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] rawProd;

  vcm_mul #(.N(WIDTH)) u_core (.aIn(opA), .bIn(opB), .product(rawProd));

  if (OUT_REG) begin : g_reg
    logic [PW-1:0] prodQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          prodQ <= '0;
      else if (ctl.clear) prodQ <= '0;
      else if (ctl.load)  prodQ <= rawProd;
    end
    assign product = prodQ;
  end else begin : g_comb
    logic unusedIn;
    assign unusedIn = clk ^ rstN ^ ctl.load ^ ctl.clear;
    assign product  = rawProd;
  end
endmodule

// File: rtl/vcx_multiplier.sv
module vcx_multiplier
  import vcm_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  if (!isPow2(WIDTH) || WIDTH > 16) begin : g_badWidth
    $error("WIDTH must be a power of two between 2 and 16");
  end

  vcmCtl_t ctl;

  vcm_ctrl u_ctrl (.rstN(rstN), .ctl(ctl));

  vcm_datapath #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .opA(opA), .opB(opB), .product(product)
  );

  if (OUT_REG) begin : g_chkReg
    // R8: registered product is one edge behind the operands
    a_r8_latency: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> product == (PW'($past(opA)) * PW'($past(opB))))
      else $error("registered product wrong");
  end else begin : g_chkComb
    // R9: combinational product tracks operands
    always_comb begin
      if (!$isunknown({opA, opB})) begin
        a_r9_comb: assert (product == PW'(opA) * PW'(opB))
          else $error("combinational product wrong");
      end
    end
  end
endmodule

// File: tb/vcx_multiplier_test.sv
`timescale 1ns/1ps
module vcx_multiplier_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [1:0]  a2 = '0, b2 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [15:0] p8;
  logic [3:0]  p2;
  logic [7:0]  p4;
  logic [31:0] p16;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vcx_multiplier #(.WIDTH(8),  .OUT_REG(1'b1)) uut (.clk(clk), .rstN(rstN), .opA(a8),  .opB(b8),  .product(p8));
  vcx_multiplier #(.WIDTH(2),  .OUT_REG(1'b1)) u2  (.clk(clk), .rstN(rstN), .opA(a2),  .opB(b2),  .product(p2));
  vcx_multiplier #(.WIDTH(4),  .OUT_REG(1'b0)) u4  (.clk(clk), .rstN(rstN), .opA(a4),  .opB(b4),  .product(p4));
  vcx_multiplier #(.WIDTH(16), .OUT_REG(1'b1)) u16 (.clk(clk), .rstN(rstN), .opA(a16), .opB(b16), .product(p16));

  function automatic logic [31:0] refMul(input logic [15:0] x, input logic [15:0] y);
    return 32'(x) * 32'(y);
  endfunction

  function automatic bit legalSmall(input logic [3:0] v);
    return v == 0 || v == 1 || v == 2 || v == 3 || v == 4 || v == 6 || v == 9;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyVec(input logic [7:0] x, input logic [7:0] y,
                          input logic [15:0] x16, input logic [15:0] y16);
    logic [7:0] lowRef;
    a8 = x; b8 = y; a2 = x[1:0]; b2 = y[1:0]; a4 = x[3:0]; b4 = y[3:0];
    a16 = x16; b16 = y16;
    #1;
    chk("R9 comb 4-bit", 32'(p4), refMul(16'(a4), 16'(b4)));
    @(posedge clk);
    @(negedge clk);
    chk("R7 8-bit", 32'(p8), refMul(16'(x), 16'(y)));
    chk("R7 16-bit", p16, refMul(x16, y16));
    chk("R7 2-bit", 32'(p2), refMul(16'(a2), 16'(b2)));
    chk("R1 bit0", 32'(p2[0]), 32'(a2[0] & b2[0]));
    chk("R2 bit1", 32'(p2[1]), 32'((a2[1] & b2[0]) ^ (a2[0] & b2[1])));
    chk("R3 bit2", 32'(p2[2]), 32'((a2[1] & b2[1]) ^ ((a2[1] & b2[0]) & (a2[0] & b2[1]))));
    chk("R3 bit3", 32'(p2[3]), 32'(a2 == 2'd3 && b2 == 2'd3));
    chk("R4 legal value", 32'(legalSmall(p2)), 32'd1);
    lowRef = 8'(x[3:0]) * 8'(y[3:0]);
    chk("R6 low half", 32'(p8[3:0]), 32'(lowRef[3:0]));
    chk("R10 upper merge", 32'(p8[15:4]), 32'(refMul(16'(x), 16'(y)) >> 4));
    chk("R5 ripple 16-bit upper", p16 >> 8, refMul(x16, y16) >> 8);
  endtask

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    a8 = 8'hFF; b8 = 8'hFF; a2 = 2'd3; b2 = 2'd3; a16 = 16'hFFFF; b16 = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R8 reset 8-bit", 32'(p8), 32'd0);
    chk("R8 reset 16-bit", p16, 32'd0);
    chk("R8 reset 2-bit", 32'(p2), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // exhaustive 8-bit (covers all 2-bit and 4-bit pairs), random 16-bit
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        applyVec(8'(i), 8'(j), 16'($urandom), 16'($urandom));
      end
    end
    // 16-bit corners
    applyVec(8'h00, 8'hFF, 16'h0000, 16'hFFFF);
    applyVec(8'h01, 8'hFF, 16'h0001, 16'hFFFF);
    applyVec(8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF);
    applyVec(8'hFF, 8'h01, 16'hFFFF, 16'h0001);
    applyVec(8'h80, 8'h80, 16'h8000, 16'h8000);
    applyVec(8'h55, 8'hAA, 16'h5555, 16'hAAAA);
    for (int k = 0; k < 200; k++) begin
      applyVec(8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom));
    end
    // R8: back into reset clears the registered outputs
    rstN = 1'b0;
    @(negedge clk);
    chk("R8 reclear 8-bit", 32'(p8), 32'd0);
    chk("R8 reclear 16-bit", p16, 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule